// File: doc/BRIEF.md
# Multi-Channel PWM Controller with Staged Updates

This block generates up to four independent pulse-width modulated outputs. Each channel owns a 32-byte register window on a simple write-strobe register bus. The window holds a clock divider value (prescale), a period length in divided ticks (modulus), a high-time length in divided ticks (duty) and an enable bit. A prescaler counts source clocks, and a period counter advances once per divided tick. The output is high while the period counter is below the active duty count.

Reconfiguration is glitch-free. A duty write captures the current prescale and modulus together with the new duty into a pending set. The running period finishes on the old values, and the pending set becomes active at the period boundary. Clearing enable is the exception: it stops the channel on the next clock, mid-period. Software writes prescale and modulus first and duty last.

Each channel runs a three-state machine:
- CH_OFF: the channel is stopped.
- CH_RUN: the channel is running with no update waiting.
- CH_ARMED: the channel is running with a pending set waiting for the boundary.

The transitions are:
- start: CH_OFF to CH_RUN, on an enable write of 1.
- arm: CH_RUN to CH_ARMED, on a duty write.
- commit: CH_ARMED to CH_RUN, at a period boundary with no duty write in that cycle.
- rearm: CH_ARMED stays in CH_ARMED, on a duty write, which replaces the pending set.
- stop: CH_RUN or CH_ARMED to CH_OFF, on an enable write of 0.

Top module: `pwm_staged_ctrl`

## Requirements
- R1: The channel window base is the channel index times 32, taken from address bits [7:5]. Within a window:
  - offset 0x00 holds prescale, bits [7:0];
  - offset 0x04 holds modulus, bits [7:0];
  - offset 0x08 holds duty, bits [15:0];
  - offset 0x18 holds enable, bit 0.
  A read returns the last value written, masked to the field width.
- R2: Reads return zero at any other offset and at any channel index of NUM_CH or above. Writes there change no register and no output.
- R3: A running channel repeats a period of (P+1)*Me source clocks, where P is prescale and Me is the modulus (a modulus of 0 acts as 1). The output is high for the first (P+1)*D clocks of each period, where D is duty. The first period starts in the clock after the enabling write.
- R4: If D is greater than or equal to Me, the output is high for the whole period. If D is 0, the output stays low.
- R5: A duty write to a running channel snapshots prescale, modulus and the new duty. The current period completes on the old values, and the new values apply from the next period.
- R6: Writing prescale or modulus without a following duty write leaves the running waveform unchanged.
- R7: Writing 0 to enable drives the output low from the next clock, even mid-period.
- R8: While a channel is disabled, a duty write becomes active at once. Disabling a channel with a pending update makes that update active. Re-enabling starts a fresh period from phase 0.
- R9: The channels run independently; each has its own configuration and phase.
- R10: After reset, all outputs are low and all registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | 8 | Byte address: channel in [7:5], offset in [4:0] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pwm_out | output | 4 | One PWM output per channel |

## Verification
The bench makes a duty write partway through a period, after separate prescale and modulus writes. A design that commits on the write itself, or on each register write, would produce one mixed period before the boundary. A design that ignores the snapshot would never switch.

It clears enable while the output is high. A design that waits for the period to end would keep the output high for several more clocks.

The bench also covers the edges of the comparison:
- duty of 0;
- duty equal to or above the modulus;
- modulus of 0.
An off-by-one comparison would show a stray high or low clock at these edges.

Finally, it disables a channel with an update pending and then re-enables it. This exposes designs that drop the pending set or resume mid-phase.

// File: rtl/pwm_staged_pkg.sv
`timescale 1ns/1ps
package pwm_staged_pkg;
    localparam int PRE_W     = 8;
    localparam int MOD_W     = 8;
    localparam int DUTY_W    = 16;
    localparam int WIN_SHIFT = 5;

    localparam logic [WIN_SHIFT-1:0] OFS_PRE  = 5'h00;
    localparam logic [WIN_SHIFT-1:0] OFS_MOD  = 5'h04;
    localparam logic [WIN_SHIFT-1:0] OFS_DUTY = 5'h08;
    localparam logic [WIN_SHIFT-1:0] OFS_EN   = 5'h18;

    typedef enum logic [1:0] {
        CH_OFF   = 2'd0,
        CH_RUN   = 2'd1,
        CH_ARMED = 2'd2
    } ch_state_e;

    typedef struct packed {
        logic [PRE_W-1:0]  pre;
        logic [MOD_W-1:0]  modv;
        logic [DUTY_W-1:0] duty;
    } ch_cfg_t;
endpackage

// File: rtl/pwm_staged_regs.sv
`timescale 1ns/1ps
module pwm_staged_regs
    import pwm_staged_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel,
    input  logic                 wr,
    input  logic [WIN_SHIFT-1:0] ofs,
    input  logic [DUTY_W-1:0]    wdata,
    output logic [PRE_W-1:0]     sh_pre,
    output logic [MOD_W-1:0]     sh_mod,
    output logic                 duty_wr,
    output logic                 en_wr,
    output logic                 en_bit,
    output logic [DATA_W-1:0]    rdata
);
    logic [DUTY_W-1:0] sh_duty;
    logic              en_q;
    logic              wr_pre, wr_mod, wr_duty, wr_en;

    assign wr_pre  = sel && wr && (ofs == OFS_PRE);
    assign wr_mod  = sel && wr && (ofs == OFS_MOD);
    assign wr_duty = sel && wr && (ofs == OFS_DUTY);
    assign wr_en   = sel && wr && (ofs == OFS_EN);

    assign duty_wr = wr_duty;
    assign en_wr   = wr_en;
    assign en_bit  = wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_pre  <= '0;
            sh_mod  <= '0;
            sh_duty <= '0;
            en_q    <= 1'b0;
        end else begin
            if (wr_pre)  sh_pre  <= wdata[PRE_W-1:0];
            if (wr_mod)  sh_mod  <= wdata[MOD_W-1:0];
            if (wr_duty) sh_duty <= wdata;
            if (wr_en)   en_q    <= wdata[0];
        end
    end

    always_comb begin
        rdata = '0;
        case (ofs)
            OFS_PRE:  rdata = DATA_W'(sh_pre);
            OFS_MOD:  rdata = DATA_W'(sh_mod);
            OFS_DUTY: rdata = DATA_W'(sh_duty);
            OFS_EN:   rdata = DATA_W'(en_q);
            default:  rdata = '0;
        endcase
    end

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && wr) |=> ($stable(sh_pre) && $stable(sh_mod) && $stable(sh_duty) && $stable(en_q))); // R2
endmodule

// File: rtl/pwm_staged_chan.sv
`timescale 1ns/1ps
module pwm_staged_chan
    import pwm_staged_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PRE_W-1:0]  sh_pre,
    input  logic [MOD_W-1:0]  sh_mod,
    input  logic              duty_wr,
    input  logic [DUTY_W-1:0] duty_in,
    input  logic              en_wr,
    input  logic              en_bit,
    output logic              pwm_o
);
    ch_state_e         state_q, state_d;
    ch_cfg_t           act_q, pend_q, snap;
    logic [PRE_W-1:0]  pre_q;
    logic [MOD_W-1:0]  cnt_q;
    logic [MOD_W-1:0]  last;
    logic              en_set, en_clr, pre_wrap, boundary;

    assign en_set   = en_wr && en_bit;
    assign en_clr   = en_wr && !en_bit;
    assign last     = (act_q.modv == '0) ? '0 : act_q.modv - MOD_W'(1);
    assign pre_wrap = (pre_q == act_q.pre);
    assign boundary = (state_q != CH_OFF) && pre_wrap && (cnt_q == last);

    always_comb begin
        snap.pre  = sh_pre;
        snap.modv = sh_mod;
        snap.duty = duty_in;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_OFF:   if (en_set) state_d = CH_RUN;
            CH_RUN: begin
                if (en_clr)       state_d = CH_OFF;
                else if (duty_wr) state_d = CH_ARMED;
            end
            CH_ARMED: begin
                if (en_clr)                     state_d = CH_OFF;
                else if (boundary && !duty_wr)  state_d = CH_RUN;
            end
            default:  state_d = CH_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q  <= '0;
            pend_q <= '0;
            pre_q  <= '0;
            cnt_q  <= '0;
        end else begin
            unique case (state_q)
                CH_OFF: begin
                    pre_q <= '0;
                    cnt_q <= '0;
                    if (duty_wr) act_q <= snap;
                end
                CH_RUN, CH_ARMED: begin
                    if (en_clr) begin
                        pre_q <= '0;
                        cnt_q <= '0;
                        if (state_q == CH_ARMED) act_q <= pend_q;
                    end else begin
                        if (boundary) begin
                            pre_q <= '0;
                            cnt_q <= '0;
                            if (state_q == CH_ARMED) act_q <= pend_q;
                        end else if (pre_wrap) begin
                            pre_q <= '0;
                            cnt_q <= cnt_q + MOD_W'(1);
                        end else begin
                            pre_q <= pre_q + PRE_W'(1);
                        end
                        if (duty_wr) pend_q <= snap;
                    end
                end
                default: begin
                    pre_q <= '0;
                    cnt_q <= '0;
                end
            endcase
        end
    end

    always_comb begin
        pwm_o = (state_q != CH_OFF) && (DUTY_W'(cnt_q) < act_q.duty);
    end

    AST_STOP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (en_clr && state_q != CH_OFF) |=> !pwm_o); // R7
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != CH_OFF) |-> (cnt_q <= last)); // R3
    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != CH_OFF && !boundary && !en_clr) |=> $stable(act_q)); // R5
    AST_PERIOD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && !en_clr) |=> (cnt_q == '0 && pre_q == '0)); // R3
    AST_START_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_OFF && en_set) |=> (pre_q == '0 && cnt_q == '0 && state_q == CH_RUN)); // R8
endmodule

// File: rtl/pwm_staged_ctrl.sv
`timescale 1ns/1ps
module pwm_staged_ctrl
    import pwm_staged_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);
    localparam int CH_IDX_W = ADDR_W - WIN_SHIFT;

    logic [CH_IDX_W-1:0]  ch_idx;
    logic [WIN_SHIFT-1:0] ofs;
    logic [DATA_W-1:0]    rd_arr [NUM_CH];
    logic                 unused_wdata_hi;

    assign ch_idx          = bus_addr[ADDR_W-1:WIN_SHIFT];
    assign ofs             = bus_addr[WIN_SHIFT-1:0];
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:DUTY_W];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic             sel;
        logic [PRE_W-1:0] sh_pre;
        logic [MOD_W-1:0] sh_mod;
        logic             duty_wr, en_wr, en_bit;

        assign sel = (ch_idx == CH_IDX_W'(g));

        pwm_staged_regs #(.DATA_W(DATA_W)) u_regs (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel     (sel),
            .wr      (bus_wr),
            .ofs     (ofs),
            .wdata   (bus_wdata[DUTY_W-1:0]),
            .sh_pre  (sh_pre),
            .sh_mod  (sh_mod),
            .duty_wr (duty_wr),
            .en_wr   (en_wr),
            .en_bit  (en_bit),
            .rdata   (rd_arr[g])
        );

        pwm_staged_chan u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .sh_pre  (sh_pre),
            .sh_mod  (sh_mod),
            .duty_wr (duty_wr),
            .duty_in (bus_wdata[DUTY_W-1:0]),
            .en_wr   (en_wr),
            .en_bit  (en_bit),
            .pwm_o   (pwm_out[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (ch_idx == CH_IDX_W'(i)) bus_rdata = rd_arr[i];
        end
    end

    AST_ABSENT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(ch_idx) >= NUM_CH) |-> (bus_rdata == '0)); // R2
endmodule

// File: tb/pwm_staged_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwm_staged_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_out;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    pwm_staged_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    function automatic logic [7:0] adr(input int ch, input int ofs);
        return 8'((ch << 5) | ofs);
    endfunction

    function automatic logic model(input int p, input int m, input int d, input int phase);
        int me, per, hi;
        me  = (m == 0) ? 1 : m;
        per = (p + 1) * me;
        hi  = (d >= me) ? per : (p + 1) * d;
        return ((phase % per) < hi);
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic setup(input int ch, input int p, input int m, input int d);
        wr(adr(ch, 8'h18), 32'd0);
        wr(adr(ch, 8'h00), 32'(p));
        wr(adr(ch, 8'h04), 32'(m));
        wr(adr(ch, 8'h08), 32'(d));
        wr(adr(ch, 8'h18), 32'd1);
    endtask

    task automatic run_check(input int ch, input int p, input int m, input int d,
                             input int ph0, input int n, input string tag);
        int  errs = 0;
        logic fa = 1'b0, fe = 1'b0;
        for (int k = 0; k < n; k++) begin
            logic e;
            @(negedge clk);
            e = model(p, m, d, ph0 + k);
            if (pwm_out[ch] !== e) begin
                if (errs == 0) begin fa = pwm_out[ch]; fe = e; end
                errs++;
            end
        end
        chk(errs == 0, tag, fa, fe);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        chk(pwm_out == 4'b0, "R10 outputs low after reset", pwm_out, 0);
        rd(adr(0, 8'h08), v);
        chk(v == 0, "R10 duty reads zero after reset", v, 0);
        rd(adr(3, 8'h18), v);
        chk(v == 0, "R10 enable reads zero after reset", v, 0);
    endtask

    task automatic t_regmap;
        logic [31:0] v;
        wr(adr(2, 8'h00), 32'h0000_01AB);
        wr(adr(2, 8'h04), 32'hFFFF_FF37);
        wr(adr(2, 8'h08), 32'h0001_2345);
        wr(adr(2, 8'h18), 32'h0000_0003);
        rd(adr(2, 8'h00), v); chk(v == 32'hAB,   "R1 prescale readback", v, 32'hAB);
        rd(adr(2, 8'h04), v); chk(v == 32'h37,   "R1 modulus readback", v, 32'h37);
        rd(adr(2, 8'h08), v); chk(v == 32'h2345, "R1 duty readback", v, 32'h2345);
        rd(adr(2, 8'h18), v); chk(v == 32'h1,    "R1 enable readback", v, 32'h1);
        wr(adr(2, 8'h18), 32'h0);
        rd(adr(2, 8'h18), v); chk(v == 32'h0,    "R1 enable cleared readback", v, 0);
    endtask

    task automatic t_unmapped;
        logic [31:0] v;
        wr(adr(0, 8'h0C), 32'hFFFF_FFFF);
        rd(adr(0, 8'h0C), v); chk(v == 0, "R2 unmapped offset reads zero", v, 0);
        wr(adr(4, 8'h08), 32'h0000_00FF);
        wr(adr(4, 8'h18), 32'h1);
        rd(adr(4, 8'h18), v); chk(v == 0, "R2 absent channel reads zero", v, 0);
        rd(adr(7, 8'h08), v); chk(v == 0, "R2 absent channel duty zero", v, 0);
        rd(adr(0, 8'h00), v); chk(v == 0, "R2 write elsewhere left ch0 intact", v, 0);
        repeat (4) @(negedge clk);
        chk(pwm_out == 4'b0, "R2 absent writes do not drive outputs", pwm_out, 0);
    endtask

    task automatic t_wave;
        setup(0, 1, 4, 1); run_check(0, 1, 4, 1, 0, 24, "R3 P1 M4 D1 waveform");
        setup(0, 2, 3, 2); run_check(0, 2, 3, 2, 0, 27, "R3 P2 M3 D2 waveform");
        setup(0, 1, 0, 1); run_check(0, 1, 0, 1, 0, 8,  "R3 modulus 0 acts as 1");
    endtask

    task automatic t_extremes;
        setup(0, 0, 4, 7); run_check(0, 0, 4, 7, 0, 12, "R4 duty above modulus high");
        setup(0, 1, 5, 5); run_check(0, 1, 5, 5, 0, 20, "R4 duty equal modulus high");
        setup(0, 1, 4, 0); run_check(0, 1, 4, 0, 0, 16, "R4 duty zero low");
    endtask

    task automatic t_staged;
        int  e_old = 0, e_new = 0;
        logic fa = 0, fe = 0, ga = 0, ge = 0;
        setup(0, 1, 4, 1);
        for (int k = 0; k < 28; k++) begin
            logic e;
            @(negedge clk);
            e = (k < 8) ? model(1, 4, 1, k) : model(0, 5, 3, k - 8);
            if (pwm_out[0] !== e) begin
                if (k < 8) begin if (e_old == 0) begin fa = pwm_out[0]; fe = e; end e_old++; end
                else       begin if (e_new == 0) begin ga = pwm_out[0]; ge = e; end e_new++; end
            end
            bus_wr = 1'b0;
            if (k == 2) begin bus_wr = 1'b1; bus_addr = adr(0, 8'h00); bus_wdata = 32'd0; end
            if (k == 3) begin bus_wr = 1'b1; bus_addr = adr(0, 8'h04); bus_wdata = 32'd5; end
            if (k == 4) begin bus_wr = 1'b1; bus_addr = adr(0, 8'h08); bus_wdata = 32'd3; end
        end
        bus_wr = 1'b0;
        chk(e_old == 0, "R6 period before boundary keeps old settings", fa, fe);
        chk(e_new == 0, "R5 new settings from the boundary on", ga, ge);
    endtask

    task automatic t_stop;
        int errs = 0;
        logic fa = 0, fe = 0;
        setup(0, 3, 4, 2);
        for (int k = 0; k < 11; k++) begin
            logic e;
            @(negedge clk);
            e = (k <= 2) ? model(3, 4, 2, k) : 1'b0;
            if (pwm_out[0] !== e) begin if (errs == 0) begin fa = pwm_out[0]; fe = e; end errs++; end
            bus_wr = 1'b0;
            if (k == 2) begin bus_wr = 1'b1; bus_addr = adr(0, 8'h18); bus_wdata = 32'd0; end
        end
        bus_wr = 1'b0;
        chk(errs == 0, "R7 disable stops output mid period", fa, fe);
    endtask

    task automatic t_pending_disable;
        setup(0, 0, 4, 1);
        wr(adr(0, 8'h08), 32'd3);
        wr(adr(0, 8'h18), 32'd0);
        wr(adr(0, 8'h18), 32'd1);
        run_check(0, 0, 4, 3, 0, 12, "R8 pending update kept across disable");
    endtask

    task automatic t_indep;
        wr(adr(0, 8'h18), 32'd0);
        wr(adr(1, 8'h00), 32'd0); wr(adr(1, 8'h04), 32'd3); wr(adr(1, 8'h08), 32'd1);
        wr(adr(3, 8'h00), 32'd1); wr(adr(3, 8'h04), 32'd2); wr(adr(3, 8'h08), 32'd1);
        wr(adr(1, 8'h18), 32'd1);
        wr(adr(3, 8'h18), 32'd1);
        run_check(3, 1, 2, 1, 0, 12, "R9 channel 3 own waveform");
        run_check(1, 0, 3, 1, 13, 12, "R9 channel 1 own waveform");
        chk(pwm_out[0] == 1'b0, "R9 channel 0 stays off", pwm_out[0], 0);
    endtask

    initial begin
        #1_000_000;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_regmap();
        t_unmapped();
        t_wave();
        t_extremes();
        t_staged();
        t_stop();
        t_pending_disable();
        t_indep();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule